// File: doc/BRIEF.md
# SPI Daisy-Chain Command Master

This block is a register-attached SPI master. Software loads up to sixteen 32-bit command words into a buffer, then writes a length/control word. That write starts the transfer. In chain mode every buffered word is shifted out inside a single chip-select window, so each device of a daisy chain ends up holding one word. In single-device multi-write mode each word becomes its own chip-select-framed command to one device.

The serial interface runs in mode 0. SCK idles low and is derived from the system clock by a parameterised half-period divider. MOSI changes after falling edges, and MISO is sampled on rising edges. Data goes out most significant bit first. The last 32 bits seen on MISO are kept in a read-back register that is refreshed once the whole transfer finishes.

The controller is a five-state machine:
- IDLE: waits for a start.
- LEAD: chip select is low for half a period before the first rising edge.
- SHIFT: clocks the bits.
- TAIL: half a period after the last falling edge, then chip select rises.
- GAP: chip select is held high for a full SCK period between commands in multi-write mode.

The transitions are:
- IDLE to LEAD on a valid length write.
- LEAD to SHIFT on the divider tick.
- SHIFT to TAIL after the last bit of the frame. That is the final word in chain mode, or every word in multi-write mode.
- TAIL to IDLE after the final word.
- TAIL to GAP when words remain.
- GAP to LEAD after two ticks.

Top module: `spi_chain_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, the busy bit (bit 31 of offset 0x11) reads 0, and the read-back at offset 0x12 reads 0.
- R2: Offsets 0x00 to 0x0F are sixteen 32-bit word buffers. Each one reads back exactly what was last written to it.
- R3: Offset 0x11 is the length/control register. Bits 4:0 give the word count (1 to 16), bit 7 selects multi-write mode, and on read bit 31 shows busy. A write with a count of 1 to 16 stores the fields and starts a transfer. A count of 0 or above 16 is neither stored nor starts anything.
- R4: Each word is sent MSB first, beginning with bit 31, with all 32 bits shifted. MOSI never changes while SCK is high.
- R5: In chain mode (bit 7 = 0), the words from buffer 0 up to count-1 go out in index order in one chip-select-low window of 32×count SCK cycles.
- R6: In multi-write mode (bit 7 = 1), each buffered word is sent in its own chip-select-low window of 32 SCK cycles, in index order, giving count windows.
- R7: Between two windows of one multi-write transfer, spi_cs_n stays high for at least 2×CLK_DIV system clocks.
- R8: SCK has a period of 2×CLK_DIV system clocks, and each level lasts at least CLK_DIV clocks.
- R9: While busy, writes to the buffers and to the length register are ignored.
- R10: Offset 0x12 returns the last 32 bits sampled on MISO. It changes only when a transfer completes, and keeps its old value while busy.
- R11: SCK is low whenever spi_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | WORD_W | Register write data |
| bus_rdata | output | WORD_W | Register read data (combinational on bus_addr) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with CLK_DIV = 2 and keeps the default sixteen 32-bit words. At that divider a full sixteen-word chain frame takes about two thousand system clocks, so the following all fit in a short run:
- a single-word frame;
- a maximal chain frame;
- a multi-write burst;
- writes issued while busy.

A half-period of two clocks still leaves a visible gap between the divider ticks. This lets the bench and the checker tell a correct SCK period, chip-select gap and MOSI hold from a design that toggles too early. The MISO model rotates a fixed pattern, so any frame length must return that pattern as read-back.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } spi_state_t;

    localparam logic [4:0] OFS_CTRL     = 5'h11;
    localparam logic [4:0] OFS_READBACK = 5'h12;
    localparam int         MODE_BIT     = 7;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_chain_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int WORD_W = 32,
    localparam int IW    = $clog2(WORDS),
    localparam int CW    = $clog2(WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [4:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic [WORD_W-1:0] readback,
    input  logic [IW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] tx_word,
    output logic              start,
    output logic              multi,
    output logic [CW-1:0]     count
);
    logic              wr_ok;
    logic [CW-1:0]     len_in;
    logic              len_ok;
    logic [WORD_W-1:0] words [WORDS];
    logic [WORD_W-1:0] status;

    assign wr_ok  = we && !busy;
    assign len_in = wdata[CW-1:0];
    assign len_ok = (len_in != '0) && (len_in <= CW'(WORDS));
    assign start  = wr_ok && (addr == OFS_CTRL) && len_ok;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_ok && addr == 5'(g)) begin
                word_q <= wdata;
            end
        end
        assign words[g] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            multi <= 1'b0;
        end else if (start) begin
            count <= len_in;
            multi <= wdata[MODE_BIT];
        end
    end

    assign tx_word = words[rd_idx];

    always_comb begin
        status           = '0;
        status[WORD_W-1] = busy;
        status[MODE_BIT] = multi;
        status[CW-1:0]   = count;
    end

    always_comb begin
        if (int'(addr) < WORDS) begin
            rdata = words[addr[IW-1:0]];
        end else if (addr == OFS_CTRL) begin
            rdata = status;
        end else if (addr == OFS_READBACK) begin
            rdata = readback;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
    import spi_chain_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int NUM_WORDS = 16,
    parameter int WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int IW = $clog2(NUM_WORDS);
    localparam int CW = $clog2(NUM_WORDS + 1);
    localparam int BW = $clog2(WORD_W);

    spi_state_t        state_q, state_d;
    logic              tick, busy, start, cfg_multi;
    logic [CW-1:0]     cfg_count;
    logic [IW-1:0]     word_idx, rd_idx;
    logic [WORD_W-1:0] tx_word, tx_sr, rx_sr, rb_q;
    logic [BW-1:0]     bit_cnt;
    logic              sck_q, cs_q, gap_q;
    logic              last_bit, last_word;

    assign busy      = (state_q != ST_IDLE);
    assign rd_idx    = (state_q == ST_IDLE) ? '0 : word_idx + 1'b1;
    assign last_bit  = (bit_cnt == BW'(WORD_W - 1));
    assign last_word = ((CW'(word_idx) + CW'(1)) == cfg_count);

    spi_regfile #(.WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .busy     (busy),
        .readback (rb_q),
        .rd_idx   (rd_idx),
        .rdata    (bus_rdata),
        .tx_word  (tx_word),
        .start    (start),
        .multi    (cfg_multi),
        .count    (cfg_count)
    );

    spi_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && sck_q && last_bit && (last_word || cfg_multi))
                          state_d = ST_TAIL;
            ST_TAIL:  if (tick) state_d = last_word ? ST_IDLE : ST_GAP;
            ST_GAP:   if (tick && gap_q) state_d = ST_LEAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            gap_q    <= 1'b0;
            word_idx <= '0;
            bit_cnt  <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            rb_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cs_q     <= 1'b0;
                    word_idx <= '0;
                    bit_cnt  <= '0;
                    tx_sr    <= tx_word;
                end
                ST_LEAD: if (tick) begin
                    sck_q <= 1'b1;
                    rx_sr <= {rx_sr[WORD_W-2:0], spi_miso};
                end
                ST_SHIFT: if (tick) begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_sr <= {rx_sr[WORD_W-2:0], spi_miso};
                    end else begin
                        sck_q <= 1'b0;
                        if (!last_bit) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sr   <= {tx_sr[WORD_W-2:0], 1'b0};
                        end else if (!last_word && !cfg_multi) begin
                            bit_cnt  <= '0;
                            word_idx <= word_idx + 1'b1;
                            tx_sr    <= tx_word;
                        end
                    end
                end
                ST_TAIL: if (tick) begin
                    cs_q  <= 1'b1;
                    gap_q <= 1'b0;
                    if (last_word) rb_q <= rx_sr;
                end
                ST_GAP: if (tick) begin
                    if (!gap_q) begin
                        gap_q <= 1'b1;
                    end else begin
                        cs_q     <= 1'b0;
                        word_idx <= word_idx + 1'b1;
                        bit_cnt  <= '0;
                        tx_sr    <= tx_word;
                    end
                end
                default: ;
            endcase
        end
    end

    assign spi_sck  = sck_q;
    assign spi_cs_n = cs_q;
    assign spi_mosi = tx_sr[WORD_W-1];

endmodule

// File: rtl/spi_chain_checker.sv
module spi_chain_checker #(
    parameter int CLK_DIV = 4,
    parameter int CW      = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sck,
    input logic          cs_n,
    input logic          mosi,
    input logic          busy,
    input logic [CW-1:0] cnt,
    input logic          multi
);
    localparam int GAP_MIN = 2 * CLK_DIV;
    localparam int HW = $clog2(GAP_MIN + 1);

    logic [HW-1:0] hi_cnt;
    logic [HW-1:0] hold_cnt;
    logic          sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= HW'(GAP_MIN);
            hold_cnt <= HW'(GAP_MIN);
            sck_d    <= 1'b0;
        end else begin
            sck_d <= sck;
            if (!cs_n)                     hi_cnt <= '0;
            else if (hi_cnt != HW'(GAP_MIN)) hi_cnt <= hi_cnt + 1'b1;
            if (sck != sck_d)                hold_cnt <= '0;
            else if (hold_cnt != HW'(GAP_MIN)) hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assert_sck_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cnt) && $stable(multi)));

    assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= HW'(GAP_MIN)));

    assert_sck_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sck) || $fell(sck)) |-> (hold_cnt >= HW'(CLK_DIV - 1)));

endmodule

bind spi_chain_master spi_chain_checker #(.CLK_DIV(CLK_DIV), .CW(CW)) u_check (
    .clk   (clk),
    .rst_n (rst_n),
    .sck   (spi_sck),
    .cs_n  (spi_cs_n),
    .mosi  (spi_mosi),
    .busy  (busy),
    .cnt   (cfg_count),
    .multi (cfg_multi)
);

// File: tb/tb_spi_chain_master.sv
module tb_spi_chain_master;
    localparam int DIV = 2;
    localparam int W   = 32;
    localparam time TCLK = 20ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [W-1:0] exp_words [$];
    int           exp_frames [$];

    logic [W-1:0] miso_pat = 32'hC3A5_0F96;
    logic [W-1:0] miso_sr  = '0;
    logic         pat_load = 1'b0;

    spi_chain_master #(.CLK_DIV(DIV), .NUM_WORDS(16), .WORD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(TCLK/2) clk = ~clk;

    task automatic note(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // MISO model: rotating pattern, advanced on each falling SCK edge
    always @(negedge spi_sck or posedge pat_load) begin
        if (pat_load) miso_sr = miso_pat;
        else          miso_sr = {miso_sr[W-2:0], miso_sr[W-1]};
    end
    assign spi_miso = miso_sr[W-1];

    // Monitor: capture MOSI, compare words and frame lengths against the queues
    logic [W-1:0] cap = '0;
    int           bits = 0;
    int           fwords = 0;
    time          last_rise = 0;
    bit           period_ok = 1;
    time          cs_rise_t = 0;
    time          gap_min = 1ms;

    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (bits > 0) begin
                int ef;
                ef = (exp_frames.size() > 0) ? exp_frames.pop_front() : -1;
                note(fwords == ef && bits == 32 * fwords, "R5/R6 frame word count",
                     W'(fwords), W'(ef));
                note(period_ok, "R8 sck period", W'(period_ok), W'(1));
            end
            bits = 0; fwords = 0; period_ok = 1;
            cs_rise_t = $time;
        end else begin
            if (bits > 0 && ($time - last_rise) != 2 * DIV * TCLK) period_ok = 0;
            last_rise = $time;
            cap = {cap[W-2:0], spi_mosi};
            bits++;
            if (bits % 32 == 0) begin
                logic [W-1:0] ew;
                ew = (exp_words.size() > 0) ? exp_words.pop_front() : 'x;
                note(cap === ew, "R4 word MSB first", cap, ew);
                fwords++;
            end
        end
    end

    always @(negedge spi_cs_n) begin
        if (cs_rise_t != 0 && ($time - cs_rise_t) < gap_min) gap_min = $time - cs_rise_t;
    end

    task automatic bus_write(input logic [4:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [W-1:0] st;
        for (int i = 0; i < 20000; i++) begin
            bus_read(5'h11, st);
            if (!st[31]) return;
        end
    endtask

    // Driver: load buffers, push expectations, start
    task automatic send(input int n, input bit multi, input logic [W-1:0] seed);
        for (int i = 0; i < n; i++) begin
            logic [W-1:0] w;
            w = seed ^ (32'h0101_0101 * (i + 1)) ^ {i[7:0], 24'h0};
            bus_write(5'(i), w);
            exp_words.push_back(w);
        end
        if (multi) for (int i = 0; i < n; i++) exp_frames.push_back(1);
        else       exp_frames.push_back(n);
        bus_write(5'h11, W'(n) | (multi ? 32'h80 : 32'h0));
    endtask

    task automatic set_pattern(input logic [W-1:0] p);
        miso_pat = p;
        #1 pat_load = 1'b1;
        #1 pat_load = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(TCLK * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            summary();
        end
    end

    initial begin
        logic [W-1:0] r;
        set_pattern(32'hC3A5_0F96);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        note(spi_cs_n === 1'b1, "R1 cs_n idle", W'(spi_cs_n), W'(1));
        note(spi_sck === 1'b0, "R1 sck idle", W'(spi_sck), W'(0));
        bus_read(5'h11, r); note(r[31] === 1'b0, "R1 busy clear", r, '0);
        bus_read(5'h12, r); note(r === '0, "R1 readback zero", r, '0);

        // R2 buffer read-back
        bus_write(5'h00, 32'hDEAD_BEEF);
        bus_write(5'h0F, 32'h1234_5678);
        bus_read(5'h00, r); note(r === 32'hDEAD_BEEF, "R2 buffer 0", r, 32'hDEAD_BEEF);
        bus_read(5'h0F, r); note(r === 32'h1234_5678, "R2 buffer 15", r, 32'h1234_5678);

        // R3 invalid counts neither stored nor started
        bus_write(5'h11, 32'h0000_0080);
        repeat (4) @(negedge clk);
        bus_read(5'h11, r); note(r === '0, "R3 count 0 ignored", r, '0);
        bus_write(5'h11, 32'h0000_0011);
        repeat (4) @(negedge clk);
        bus_read(5'h11, r); note(r === '0, "R3 count 17 ignored", r, '0);
        note(spi_cs_n === 1'b1, "R3 no start", W'(spi_cs_n), W'(1));

        // R5 single-word chain frame, R10 read-back
        send(1, 1'b0, 32'h8000_0001);
        bus_read(5'h11, r); note(r === 32'h8000_0001, "R3 status busy+count", r, 32'h8000_0001);
        wait_idle();
        bus_read(5'h12, r); note(r === 32'hC3A5_0F96, "R10 readback 1 word", r, 32'hC3A5_0F96);

        // R5 full 16-word chain frame, R9 writes while busy, R10 held while busy
        set_pattern(32'h5A5A_F00F);
        send(16, 1'b0, 32'hA5C3_3C5A);
        repeat (20) @(negedge clk);
        bus_write(5'h03, 32'hFFFF_FFFF);
        bus_write(5'h11, 32'h0000_0082);
        bus_read(5'h12, r); note(r === 32'hC3A5_0F96, "R10 held while busy", r, 32'hC3A5_0F96);
        wait_idle();
        bus_read(5'h03, r);
        note(r === (32'hA5C3_3C5A ^ (32'h0101_0101 * 4) ^ 32'h0300_0000),
             "R9 buffer write ignored", r, 32'hA5C3_3C5A ^ (32'h0101_0101 * 4) ^ 32'h0300_0000);
        bus_read(5'h11, r); note(r === 32'h0000_0010, "R9 length write ignored", r, 32'h10);
        bus_read(5'h12, r); note(r === 32'h5A5A_F00F, "R10 readback 16 words", r, 32'h5A5A_F00F);

        // R6 multi-write, R7 gaps
        set_pattern(32'h0F1E_2D3C);
        gap_min = 1ms;
        send(3, 1'b1, 32'h1357_9BDF);
        bus_read(5'h11, r); note(r === 32'h8000_0083, "R3 status multi", r, 32'h8000_0083);
        wait_idle();
        note(gap_min >= 2 * DIV * TCLK, "R7 cs gap", W'(gap_min / 1ns), W'(2 * DIV * 20));
        bus_read(5'h12, r); note(r === 32'h0F1E_2D3C, "R10 readback multi", r, 32'h0F1E_2D3C);

        // R6 multi-write with 16 words
        send(16, 1'b1, 32'h2468_ACE0);
        wait_idle();
        repeat (4) @(negedge clk);
        note(exp_words.size() == 0, "R5/R6 words consumed", W'(exp_words.size()), '0);
        note(exp_frames.size() == 0, "R6 frames consumed", W'(exp_frames.size()), '0);
        note(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R11 idle lines",
             {30'b0, spi_cs_n, spi_sck}, 32'h2);

        finished = 1;
        summary();
    end

endmodule